// File: doc/BRIEF.md
# Nested Prioritized Interrupt Controller

This block arbitrates interrupts for a small processor core. It serves a parameterised number of external interrupt lines, organised in banks of 32, plus two system inputs (non-maskable and hard fault) that always outrank the configurable lines. Each external line carries an enable flag, a pending flag, an active flag and a one-byte priority. Software reaches these through a simple word-addressed register bus. Enable and pending each have separate set and clear addresses.

Every cycle the block picks the most urgent pending, enabled source and presents it to the core with an identifier. The request is raised only if that source's group priority is strictly more urgent than the current execution priority. The execution priority is taken from every source that is still active, so preempted handlers are counted. The core answers with an entry acknowledge and later a return strobe that names the finishing handler. A run-time grouping field sets how much of each priority byte takes part in preemption. The rest of the byte only orders sources that sit in the same group.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, every enable, pending and active flag reads 0, every priority byte reads 0, the grouping field reads 0 and `req_o` is low.
- R2: A priority byte keeps only its upper PRIO_BITS bits. The lower bits are discarded on write and read as 0, so writing 0xFF with PRIO_BITS=3 reads back 0xE0. Priority word at address 0x40+w holds lines 4w..4w+3, with line 4w+k in bits 8k+7:8k.
- R3: Writing 1s to address 0x08+b sets enable bits of bank b, and writing 1s to 0x10+b clears them. Bits written as 0 are unchanged. Both addresses read back the bank's current enables.
- R4: Addresses 0x18+b (set) and 0x20+b (clear) act the same way on pending bits, and both read back the pending bits. A high level on `irq_i[n]` pends line n whenever line n is not active.
- R5: Address 0x00 is read-only and returns NUM_LINES/32-1 in bits 4:0, with 0 in all other bits.
- R6: Address 0x01 bits 2:0 hold the grouping value g. The group priority of a byte is the byte masked with 0xFF<<(g+1), truncated to 8 bits, so g=7 leaves no group bits.
- R7: Among pending and enabled sources, the one with the numerically lowest full priority byte is selected, and ties go to the lowest line number. Identifiers are 0 for non-maskable, 1 for hard fault and 2+n for line n. A disabled line is never selected.
- R8: `req_o` is high only when the selected source's group priority is strictly more urgent than the execution priority. The execution priority is the most urgent group priority among active sources, or an idle level below every configurable value when none is active.
- R9: An `ack_i` while `req_o` is high clears the presented source's pending flag and sets its active flag at the same clock edge.
- R10: `ret_i` clears the active flag of the source named on `ret_id_i`. A preempted source stays active until its own return.
- R11: Non-maskable (identifier 0) outranks hard fault (identifier 1), and both outrank every line. They cannot be disabled, and one does not preempt the other when it is the less urgent one.
- R12: A line whose level input is still high when its handler returns becomes pending again on the next clock edge.
- R13: Address 0x28+b returns the active bits of bank b, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | NUM_LINES | Level interrupt sources |
| nmi_i | input | 1 | Non-maskable level source |
| hardfault_i | input | 1 | Hard fault level source |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 8 | Register word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| req_o | output | 1 | Interrupt request to core |
| req_id_o | output | ID_W | Identifier of requested source |
| ack_i | input | 1 | Core entry acknowledge |
| ret_i | input | 1 | Core handler return strobe |
| ret_id_i | input | ID_W | Identifier of returning handler |

## Verification
The preemption decision is swept over every pair of implemented priority levels for a running and a newly pending line, under all eight grouping values. This shows whether the masking with the grouping field and the strict comparison are correct, and it covers the case where the subpriority differs but the group does not. A full sweep of byte values through one priority register separates correct bit masking from plain storage. Directed sequences cover three more things. First, tie-breaking between equal priorities against a strictly more urgent later arrival. Second, a two-deep nesting with returns in reverse order, which shows whether active flags persist under preemption. Third, the system inputs against each other and against an active line, plus level re-pend after return.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int KEY_W = 9;
  typedef logic [KEY_W-1:0] key_t;

  localparam key_t KEY_NMI  = 9'd0;
  localparam key_t KEY_HF   = 9'd1;
  localparam key_t KEY_IDLE = 9'h1FF;

  function automatic key_t line_key(input logic [7:0] b);
    return key_t'(b) + key_t'(2);
  endfunction

  function automatic logic [7:0] group_mask(input logic [2:0] g);
    logic [15:0] t;
    t = 16'h00FF << (int'(g) + 1);
    return t[7:0];
  endfunction
endpackage

// File: rtl/pic_prio_regs.sv
module pic_prio_regs #(
  parameter int NUM_LINES = 64,
  parameter int PRIO_BITS = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [5:0]  wr_word_i,
  input  logic [31:0] wr_data_i,
  output logic [7:0]  prio_o [NUM_LINES]
);
  localparam logic [7:0] IMPL_MASK = 8'(8'hFF << (8 - PRIO_BITS));

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    localparam int WORD = i / 4;
    localparam int LANE = i % 4;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prio_o[i] <= '0;
      else if (wr_en_i && wr_word_i == 6'(WORD))
        prio_o[i] <= wr_data_i[8*LANE +: 8] & IMPL_MASK;
    end
  end
endmodule

// File: rtl/pic_line_state.sv
module pic_line_state #(
  parameter int NUM_LINES = 64,
  parameter int TOTAL     = NUM_LINES + 2,
  parameter int ID_W      = $clog2(NUM_LINES + 2)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [TOTAL-1:0]     src_i,
  input  logic [NUM_LINES-1:0] set_en_i,
  input  logic [NUM_LINES-1:0] clr_en_i,
  input  logic [TOTAL-1:0]     set_pd_i,
  input  logic [TOTAL-1:0]     clr_pd_i,
  input  logic                 ack_i,
  input  logic [ID_W-1:0]      ack_id_i,
  input  logic                 ret_i,
  input  logic [ID_W-1:0]      ret_id_i,
  output logic [TOTAL-1:0]     en_o,
  output logic [TOTAL-1:0]     pend_o,
  output logic [TOTAL-1:0]     act_o
);
  for (genvar k = 0; k < TOTAL; k++) begin : g_src
    logic ack_hit, ret_hit;
    assign ack_hit = ack_i && (ack_id_i == ID_W'(k));
    assign ret_hit = ret_i && (ret_id_i == ID_W'(k));

    if (k < 2) begin : g_sys
      assign en_o[k] = 1'b1;
    end else begin : g_ext
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) en_o[k] <= 1'b0;
        else en_o[k] <= (en_o[k] | set_en_i[k-2]) & ~clr_en_i[k-2];
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_o[k] <= 1'b0;
      end else if (ack_hit) begin
        pend_o[k] <= 1'b0;
      end else begin
        pend_o[k] <= (pend_o[k] | set_pd_i[k] | (src_i[k] & ~act_o[k])) & ~clr_pd_i[k];
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      act_o[k] <= 1'b0;
      else if (ack_hit) act_o[k] <= 1'b1;
      else if (ret_hit) act_o[k] <= 1'b0;
    end
  end
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter
  import pic_pkg::*;
#(
  parameter int TOTAL = 66,
  parameter int ID_W  = $clog2(TOTAL)
) (
  input  logic [TOTAL-1:0] cand_i,
  input  key_t             full_i [TOTAL],
  input  key_t             gkey_i [TOTAL],
  output logic             valid_o,
  output logic [ID_W-1:0]  id_o,
  output key_t             gkey_o
);
  key_t best;
  always_comb begin
    valid_o = 1'b0;
    id_o    = '0;
    best    = KEY_IDLE;
    gkey_o  = KEY_IDLE;
    // ascending scan with strict compare: lowest id wins ties
    for (int k = 0; k < TOTAL; k++) begin
      if (cand_i[k] && (!valid_o || full_i[k] < best)) begin
        valid_o = 1'b1;
        id_o    = ID_W'(k);
        best    = full_i[k];
        gkey_o  = gkey_i[k];
      end
    end
  end
endmodule

// File: rtl/pic_exec_prio.sv
module pic_exec_prio
  import pic_pkg::*;
#(
  parameter int TOTAL = 66
) (
  input  logic [TOTAL-1:0] act_i,
  input  key_t             gkey_i [TOTAL],
  output key_t             exec_o
);
  always_comb begin
    exec_o = KEY_IDLE;
    for (int k = 0; k < TOTAL; k++)
      if (act_i[k] && gkey_i[k] < exec_o) exec_o = gkey_i[k];
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int NUM_LINES = 64,
  parameter int PRIO_BITS = 3,
  localparam int TOTAL    = NUM_LINES + 2,
  localparam int ID_W     = $clog2(TOTAL)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] irq_i,
  input  logic                 nmi_i,
  input  logic                 hardfault_i,
  input  logic                 bus_we_i,
  input  logic [7:0]           bus_addr_i,
  input  logic [31:0]          bus_wdata_i,
  output logic [31:0]          bus_rdata_o,
  output logic                 req_o,
  output logic [ID_W-1:0]      req_id_o,
  input  logic                 ack_i,
  input  logic                 ret_i,
  input  logic [ID_W-1:0]      ret_id_i
);
  localparam int BANKS = NUM_LINES / 32;
  localparam int WORDS = NUM_LINES / 4;
  localparam logic [7:0] A_TYPE = 8'h00;
  localparam logic [7:0] A_GRP  = 8'h01;
  localparam logic [7:0] A_ENS  = 8'h08;
  localparam logic [7:0] A_ENC  = 8'h10;
  localparam logic [7:0] A_PDS  = 8'h18;
  localparam logic [7:0] A_PDC  = 8'h20;
  localparam logic [31:0] TYPE_VAL = 32'(BANKS - 1);

  // grouping field
  logic [2:0] grp_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) grp_q <= '0;
    else if (bus_we_i && bus_addr_i == A_GRP) grp_q <= bus_wdata_i[2:0];
  end

  // set/clear decode per bank
  logic [NUM_LINES-1:0] ens_l, enc_l, pds_l, pdc_l;
  for (genvar b = 0; b < BANKS; b++) begin : g_dec
    assign ens_l[32*b +: 32] = (bus_we_i && bus_addr_i == A_ENS + 8'(b)) ? bus_wdata_i : '0;
    assign enc_l[32*b +: 32] = (bus_we_i && bus_addr_i == A_ENC + 8'(b)) ? bus_wdata_i : '0;
    assign pds_l[32*b +: 32] = (bus_we_i && bus_addr_i == A_PDS + 8'(b)) ? bus_wdata_i : '0;
    assign pdc_l[32*b +: 32] = (bus_we_i && bus_addr_i == A_PDC + 8'(b)) ? bus_wdata_i : '0;
  end

  // priority storage
  logic [7:0] prio [NUM_LINES];
  logic       prio_we;
  assign prio_we = bus_we_i && bus_addr_i[7:6] == 2'b01 && 32'(bus_addr_i[5:0]) < WORDS;

  pic_prio_regs #(.NUM_LINES(NUM_LINES), .PRIO_BITS(PRIO_BITS)) u_prio (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (prio_we),
    .wr_word_i (bus_addr_i[5:0]),
    .wr_data_i (bus_wdata_i),
    .prio_o    (prio)
  );

  // per-source flags, index = identifier
  logic [TOTAL-1:0] en_q, pend_q, act_q, cand;
  logic             ack_fire;
  assign ack_fire = ack_i && req_o;

  pic_line_state #(.NUM_LINES(NUM_LINES), .TOTAL(TOTAL), .ID_W(ID_W)) u_state (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .src_i    ({irq_i, hardfault_i, nmi_i}),
    .set_en_i (ens_l),
    .clr_en_i (enc_l),
    .set_pd_i ({pds_l, 2'b00}),
    .clr_pd_i ({pdc_l, 2'b00}),
    .ack_i    (ack_fire),
    .ack_id_i (req_id_o),
    .ret_i    (ret_i),
    .ret_id_i (ret_id_i),
    .en_o     (en_q),
    .pend_o   (pend_q),
    .act_o    (act_q)
  );
  assign cand = pend_q & en_q;

  // urgency keys
  key_t       full_key [TOTAL];
  key_t       grp_key  [TOTAL];
  logic [7:0] gmask;
  assign gmask = group_mask(grp_q);

  for (genvar k = 0; k < TOTAL; k++) begin : g_key
    if (k == 0) begin : g_nmi
      assign full_key[k] = KEY_NMI;
      assign grp_key[k]  = KEY_NMI;
    end else if (k == 1) begin : g_hf
      assign full_key[k] = KEY_HF;
      assign grp_key[k]  = KEY_HF;
    end else begin : g_ext
      assign full_key[k] = line_key(prio[k-2]);
      assign grp_key[k]  = line_key(prio[k-2] & gmask);
    end
  end

  logic best_valid;
  key_t best_gkey, exec_prio;

  pic_arbiter #(.TOTAL(TOTAL), .ID_W(ID_W)) u_arb (
    .cand_i  (cand),
    .full_i  (full_key),
    .gkey_i  (grp_key),
    .valid_o (best_valid),
    .id_o    (req_id_o),
    .gkey_o  (best_gkey)
  );

  pic_exec_prio #(.TOTAL(TOTAL)) u_exec (
    .act_i  (act_q),
    .gkey_i (grp_key),
    .exec_o (exec_prio)
  );

  assign req_o = best_valid && (best_gkey < exec_prio);

  // read path
  logic [31:0] en_rd [8], pd_rd [8], ac_rd [8];
  for (genvar b = 0; b < 8; b++) begin : g_rbank
    if (b < BANKS) begin : g_on
      assign en_rd[b] = en_q[2 + 32*b +: 32];
      assign pd_rd[b] = pend_q[2 + 32*b +: 32];
      assign ac_rd[b] = act_q[2 + 32*b +: 32];
    end else begin : g_off
      assign en_rd[b] = '0;
      assign pd_rd[b] = '0;
      assign ac_rd[b] = '0;
    end
  end

  logic [31:0] pr_rd [64];
  for (genvar w = 0; w < 64; w++) begin : g_rword
    if (w < WORDS) begin : g_on
      assign pr_rd[w] = {prio[4*w+3], prio[4*w+2], prio[4*w+1], prio[4*w]};
    end else begin : g_off
      assign pr_rd[w] = '0;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i[7:6] == 2'b01) bus_rdata_o = pr_rd[bus_addr_i[5:0]];
    else begin
      case (bus_addr_i[7:3])
        5'h00: begin
          if (bus_addr_i == A_TYPE)     bus_rdata_o = TYPE_VAL;
          else if (bus_addr_i == A_GRP) bus_rdata_o = {29'd0, grp_q};
        end
        5'h01, 5'h02: bus_rdata_o = en_rd[bus_addr_i[2:0]];
        5'h03, 5'h04: bus_rdata_o = pd_rd[bus_addr_i[2:0]];
        5'h05:        bus_rdata_o = ac_rd[bus_addr_i[2:0]];
        default:      bus_rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/pic_checker.sv
module pic_checker #(
  parameter int NUM_LINES = 64,
  parameter int PRIO_BITS = 3,
  localparam int TOTAL    = NUM_LINES + 2,
  localparam int ID_W     = $clog2(TOTAL)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_o,
  input logic [ID_W-1:0]  req_id_o,
  input logic             ack_i,
  input logic [TOTAL-1:0] act,
  input logic [TOTAL-1:0] cand,
  input logic [7:0]       bus_addr_i,
  input logic [31:0]      bus_rdata_o
);
  localparam logic [7:0] LOW = ~8'(8'hFF << (8 - PRIO_BITS));
  localparam logic [31:0] TYPE_VAL = 32'(NUM_LINES / 32 - 1);

  logic [2**ID_W-1:0] act_x, cand_x;
  assign act_x  = (2**ID_W)'(act);
  assign cand_x = (2**ID_W)'(cand);

  assert_entry_sets_active_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && req_o) |=> act_x[$past(req_id_o)]);

  assert_req_is_candidate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> cand_x[req_id_o]);

  assert_active_rise_needs_ack_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(act) > $past($countones(act))) |-> $past(ack_i && req_o));

  assert_prio_low_bits_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i[7:6] == 2'b01) |-> ((bus_rdata_o & {4{LOW}}) == 32'd0));

  assert_type_value_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == 8'h00) |-> (bus_rdata_o == TYPE_VAL));

  assert_nmi_first_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && cand[0]) |-> (req_id_o == '0));
endmodule

bind prio_irq_ctrl pic_checker #(.NUM_LINES(NUM_LINES), .PRIO_BITS(PRIO_BITS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_o       (req_o),
  .req_id_o    (req_id_o),
  .ack_i       (ack_i),
  .act         (act_q),
  .cand        (cand),
  .bus_addr_i  (bus_addr_i),
  .bus_rdata_o (bus_rdata_o)
);

// File: tb/prio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb;
  localparam int N    = 64;
  localparam int P    = 3;
  localparam int ID_W = $clog2(N + 2);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [N-1:0] irq = '0;
  logic nmi = 1'b0, hf = 1'b0;
  logic we = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic req, ack = 1'b0, ret = 1'b0;
  logic [ID_W-1:0] req_id, ret_id = '0;
  int n_vec = 0, n_bad = 0;

  always #4 clk = ~clk;

  prio_irq_ctrl #(.NUM_LINES(N), .PRIO_BITS(P)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .irq_i(irq), .nmi_i(nmi), .hardfault_i(hf),
    .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .req_o(req), .req_id_o(req_id), .ack_i(ack), .ret_i(ret), .ret_id_i(ret_id)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic do_ack();
    @(negedge clk); ack = 1'b1;
    @(posedge clk); @(negedge clk); ack = 1'b0;
  endtask

  task automatic do_ret(input int id);
    @(negedge clk); ret = 1'b1; ret_id = ID_W'(id);
    @(posedge clk); @(negedge clk); ret = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic chk_req(input string tag, input logic exp_req, input int exp_id);
    @(negedge clk);
    chk({tag, " req"}, 32'(req), 32'(exp_req));
    if (exp_req) chk({tag, " id"}, 32'(req_id), 32'(exp_id));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    do_reset();

    // R1 reset state
    foreach (addr_list[i]) ;
    for (int a = 8'h08; a < 8'h30; a++) begin
      rd(8'(a), d); chk("R1 flags reset", d, 0);
    end
    for (int w = 0; w < N/4; w++) begin
      rd(8'(8'h40 + w), d); chk("R1 prio reset", d, 0);
    end
    rd(8'h01, d); chk("R1 group reset", d, 0);
    chk_req("R1", 1'b0, 0);

    // R5 type register
    rd(8'h00, d); chk("R5 type", d, 32'(N/32 - 1));

    // R6 grouping field width
    wr(8'h01, 32'hFFFF_FFFF); rd(8'h01, d); chk("R6 group rd", d, 7);
    wr(8'h01, 32'h0000_0002); rd(8'h01, d); chk("R6 group rd", d, 2);
    wr(8'h01, 0);

    // R2 full byte sweep through one priority register, lane 2
    for (int v = 0; v < 256; v++) begin
      wr(8'h41, 32'(v) << 16);
      rd(8'h41, d);
      chk("R2 mask", d, (32'(v) & 32'(8'(8'hFF << (8 - P)))) << 16);
    end
    wr(8'h41, 0);

    // R3 enable set/clear
    wr(8'h08, 32'hA5A5_0000); wr(8'h08, 32'h0000_00F0);
    rd(8'h08, d); chk("R3 en set", d, 32'hA5A5_00F0);
    wr(8'h08, 0); rd(8'h10, d); chk("R3 en zero write", d, 32'hA5A5_00F0);
    wr(8'h10, 32'h8181_0010); rd(8'h08, d); chk("R3 en clr", d, 32'h2424_00E0);
    wr(8'h10, 0); rd(8'h10, d); chk("R3 en clr zero", d, 32'h2424_00E0);
    wr(8'h09, 32'h0000_0003); rd(8'h11, d); chk("R3 en bank1", d, 32'h3);
    wr(8'h10, 32'hFFFF_FFFF); wr(8'h11, 32'hFFFF_FFFF);
    rd(8'h08, d); chk("R3 en all clr", d, 0);

    // R4 pending set/clear (lines disabled: no request, R7)
    wr(8'h19, 32'h0004_0000); wr(8'h19, 32'h0000_0001);
    rd(8'h21, d); chk("R4 pd set", d, 32'h0004_0001);
    chk_req("R7 disabled", 1'b0, 0);
    wr(8'h21, 32'h0000_0001); rd(8'h19, d); chk("R4 pd clr", d, 32'h0004_0000);
    wr(8'h21, 0); rd(8'h19, d); chk("R4 pd clr zero", d, 32'h0004_0000);
    wr(8'h21, 32'hFFFF_FFFF);
    @(negedge clk); irq[33] = 1'b1;
    @(negedge clk); irq[33] = 1'b0;
    rd(8'h19, d); chk("R4 level pend", d, 32'h2);
    wr(8'h21, 32'hFFFF_FFFF);

    // R13 active read-only
    wr(8'h28, 32'hFFFF_FFFF); rd(8'h28, d); chk("R13 act ro", d, 0);

    // R7 selection and tie-break
    do_reset();
    wr(8'h41, 32'h0000_0040);          // line 4
    wr(8'h42, 32'h0040_0000);          // line 10
    wr(8'h4A, 32'h0000_0020);          // line 40
    wr(8'h08, (32'h1 << 4) | (32'h1 << 10));
    wr(8'h09, 32'h1 << 8);
    wr(8'h18, (32'h1 << 10) | (32'h1 << 4));
    chk_req("R7 tie lowest line", 1'b1, 6);
    wr(8'h19, 32'h1 << 8);
    chk_req("R7 lower value wins", 1'b1, 42);

    // R8/R9/R10 nesting
    do_ack();
    rd(8'h29, d); chk("R9 active set", d, 32'h100);
    rd(8'h19, d); chk("R9 pending cleared", d, 0);
    chk_req("R8 no preempt lower urgency", 1'b0, 0);
    wr(8'h41, 32'h0000_0000);          // line 4 -> most urgent
    chk_req("R8 preempt", 1'b1, 6);
    do_ack();
    rd(8'h28, d); chk("R10 inner active", d, 32'h10);
    rd(8'h29, d); chk("R10 outer stays active", d, 32'h100);
    do_ret(6);
    rd(8'h28, d); chk("R10 inner cleared", d, 0);
    rd(8'h29, d); chk("R10 outer still active", d, 32'h100);
    chk_req("R8 exec from outer", 1'b0, 0);
    do_ret(42);
    chk_req("R8 idle after returns", 1'b1, 12);

    // R11 system inputs
    do_ack();                          // line 10 active
    @(negedge clk); nmi = 1'b1; hf = 1'b1;
    chk_req("R11 nmi over all", 1'b1, 0);
    do_ack(); nmi = 1'b0;
    chk_req("R11 hf no preempt nmi", 1'b0, 0);
    wr(8'h10, 32'hFFFF_FFFF);
    do_ret(0);
    chk_req("R11 hf not disableable", 1'b1, 1);
    do_ack(); hf = 1'b0;
    do_ret(1); do_ret(12);
    chk_req("R11 quiet", 1'b0, 0);

    // R12 level re-pend
    do_reset();
    wr(8'h08, 32'h1 << 6);
    @(negedge clk); irq[6] = 1'b1;
    chk_req("R12 level req", 1'b1, 8);
    do_ack();
    rd(8'h18, d); chk("R12 pend cleared on entry", d, 0);
    rd(8'h28, d); chk("R12 active", d, 32'h40);
    do_ret(8);
    @(negedge clk);
    rd(8'h18, d); chk("R12 re-pend", d, 32'h40);
    @(negedge clk); irq[6] = 1'b0;
    wr(8'h20, 32'hFFFF_FFFF);

    // R6/R8 sweep: line 3 running at pa, line 5 arrives at pb, all groupings
    do_reset();
    for (int g = 0; g < 8; g++) begin
      for (int pa = 0; pa < 8; pa++) begin
        for (int pb = 0; pb < 8; pb++) begin
          logic [7:0] gm, ba, bb;
          logic exp;
          gm = 8'(16'h00FF << (g + 1));
          ba = 8'(pa << (8 - P));
          bb = 8'(pb << (8 - P));
          exp = (bb & gm) < (ba & gm);
          wr(8'h40, 32'(ba) << 24);
          wr(8'h41, 32'(bb) << 8);
          wr(8'h01, 32'(g));
          wr(8'h08, (32'h1 << 3) | (32'h1 << 5));
          wr(8'h18, 32'h1 << 3);
          @(negedge clk);
          if (!(req && req_id == 5)) chk("R8 sweep setup", 32'(req_id), 5);
          do_ack();
          wr(8'h18, 32'h1 << 5);
          chk_req("R6 R8 group preempt", exp, 7);
          do_ret(5);
          wr(8'h20, 32'hFFFF_FFFF);
          wr(8'h10, 32'hFFFF_FFFF);
        end
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  int addr_list [1] = '{0};
endmodule